// File: doc/BRIEF.md
# Sectioned RTC Register Access Controller

This block is the byte-wide register file that sits behind an already decoded serial slave of a real-time clock. The serial front end hands it byte-level events: a transaction start (with or without a new register address), a data byte to write, a request for a data byte, and a stop. The block keeps the register pointer, steps it after every byte, and holds each burst inside the register section where it began. It owns the control, alarm and user scratch bytes and the status byte. The seven clock bytes live in the timekeeper, so clock writes leave the block on a write strobe.

Reads of the clock bytes come from a copy taken at the start of each transaction, so a tick in the middle of a burst cannot tear the value. Clock writes pass only while an enable bit in the status byte is set. The two event flags in the status byte can be cleared by a write but never set by one, and they can optionally clear themselves at the end of a transaction that read them. While the device runs from its backup supply, every access is ignored.

Top module: `rtc_regfile_ctrl`

## Requirements
- R1: After reset the pointer is 00h, every stored byte and the status byte read 00h, and rd_valid and tm_wr_en are low.
- R2: An accepted rd_req returns, on the next cycle with rd_valid high, the byte at the pointer. Addresses 00h–06h come from the snapshot and the other addresses come from internal storage.
- R3: The sections are 00h–06h, 07h–0Bh, 0Ch–11h and 12h–13h. When an access at the last byte of a section completes, the pointer goes back to that section's first byte.
- R4: Every accepted read or write byte advances the pointer by one, following R3. A start with start_addr_vld high loads start_addr into the pointer. A start with start_addr_vld low keeps the pointer, so reading continues from the last address plus one.
- R5: Every accepted start copies tm_live into the snapshot, with byte k taken from bits [8k+7:8k]. The copy then stays unchanged until the next accepted start.
- R6: A write at 00h–06h pulses tm_wr_en one cycle later, carrying the address and the data, only when status bit 4 is 1. When that bit is 0 the write produces no strobe.
- R7: Address 09h reads 00h and ignores writes. Addresses 14h and above read 00h and ignore writes, and the pointer does not move there.
- R8: Status byte 07h holds: bit 7 = auto-clear enable (read/write), bit 4 = clock write enable (read/write), bit 2 = alarm flag, bit 1 = backup flag; all other bits read 0. An evt_alarm pulse sets the alarm flag. bat_mode high sets the backup flag. Writing 0 to a flag clears it and writing 1 leaves it unchanged. An event arriving in the same cycle as a clearing write wins.
- R9: When auto-clear is enabled and 07h was read during a transaction, an accepted stop clears both flags. A stop after a transaction that did not read 07h leaves them unchanged.
- R10: While bat_mode is high, starts, writes, reads and stops are ignored. No rd_valid, no tm_wr_en, and no change to the pointer, the storage or the snapshot.
- R11: Bytes 08h, 0Ah, 0Bh, 0Ch–11h and 12h–13h can be written and read back with no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bat_mode | input | 1 | Device running from backup supply; blocks access |
| txn_start | input | 1 | Transaction start event |
| start_addr_vld | input | 1 | Start carries a new register address |
| start_addr | input | 8 | Register address given with the start |
| wr_valid | input | 1 | Write one data byte at the pointer |
| wr_data | input | 8 | Data byte to write |
| rd_req | input | 1 | Read one data byte at the pointer |
| txn_stop | input | 1 | Transaction stop event |
| evt_alarm | input | 1 | Alarm match pulse from the timekeeper |
| tm_live | input | 56 | Live clock bytes 00h–06h, byte k at bits [8k+7:8k] |
| rd_valid | output | 1 | rd_data holds a read byte |
| rd_data | output | 8 | Read data byte |
| tm_wr_en | output | 1 | Clock byte write strobe to the timekeeper |
| tm_wr_addr | output | 8 | Clock byte address of the strobe |
| tm_wr_data | output | 8 | Clock byte data of the strobe |

## Verification
The hardest state to reach is the interaction between the status flags and the transaction boundaries. An alarm event has to coincide with a clearing write, and an auto-clearing stop has to follow a transaction that did or did not read the status byte. The bench builds these cases with directed sequences. It then runs a long seeded random mix of starts, current-address starts, writes, reads, stops, alarm pulses and backup episodes, so that bursts wrap in every section while the enable and flag bits change under them.

// File: rtl/rtcr_pkg.sv
package rtcr_pkg;

   localparam int unsigned MAP_BYTES = 20;

   localparam logic [7:0] CLK_HI   = 8'h06;
   localparam logic [7:0] CTL_LO   = 8'h07;
   localparam logic [7:0] CTL_HI   = 8'h0B;
   localparam logic [7:0] ALM_LO   = 8'h0C;
   localparam logic [7:0] ALM_HI   = 8'h11;
   localparam logic [7:0] RAM_LO   = 8'h12;
   localparam logic [7:0] RAM_HI   = 8'h13;
   localparam logic [7:0] STS_ADDR = 8'h07;
   localparam logic [7:0] GAP_ADDR = 8'h09;

   localparam int unsigned STS_AUTO = 7;
   localparam int unsigned STS_WEN  = 4;
   localparam int unsigned STS_ALM  = 2;
   localparam int unsigned STS_BAT  = 1;

   typedef enum logic [2:0] {
      SEC_CLK,
      SEC_CTL,
      SEC_ALM,
      SEC_RAM,
      SEC_NONE
   } sec_e;

   function automatic sec_e sec_of(input logic [7:0] a);
      if (a <= CLK_HI)      return SEC_CLK;
      else if (a <= CTL_HI) return SEC_CTL;
      else if (a <= ALM_HI) return SEC_ALM;
      else if (a <= RAM_HI) return SEC_RAM;
      else                  return SEC_NONE;
   endfunction

   function automatic logic [7:0] sec_first(input sec_e s);
      case (s)
         SEC_CTL: return CTL_LO;
         SEC_ALM: return ALM_LO;
         SEC_RAM: return RAM_LO;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] sec_final(input sec_e s);
      case (s)
         SEC_CLK: return CLK_HI;
         SEC_CTL: return CTL_HI;
         SEC_ALM: return ALM_HI;
         SEC_RAM: return RAM_HI;
         default: return 8'hFF;
      endcase
   endfunction

endpackage

// File: rtl/rtcr_ptr.sv
module rtcr_ptr
   import rtcr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [7:0] load_addr,
   input  logic       adv,
   output logic [7:0] ptr
);

   sec_e       cur_sec;
   logic [7:0] ptr_nxt;

   always_comb begin
      cur_sec = sec_of(ptr);
      if (cur_sec == SEC_NONE)
         ptr_nxt = ptr;
      else if (ptr == sec_final(cur_sec))
         ptr_nxt = sec_first(cur_sec);
      else
         ptr_nxt = ptr + 8'd1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr <= 8'h00;
      else if (load) ptr <= load_addr;
      else if (adv)  ptr <= ptr_nxt;
   end

   // R3: without a load the pointer never leaves its section
   a_r3_stay_in_section: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cur_sec != SEC_NONE) |=> (cur_sec == $past(cur_sec)));

   // R7: outside the map the pointer holds
   a_r7_outside_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cur_sec == SEC_NONE) |=> $stable(ptr));

endmodule

// File: rtl/rtcr_snap.sv
module rtcr_snap #(
   parameter int unsigned DW = 8,
   parameter int unsigned NB = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap,
   input  logic [NB*DW-1:0] live,
   output logic [NB*DW-1:0] snap
);

   for (genvar k = 0; k < NB; k++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   snap[k*DW +: DW] <= '0;
         else if (cap) snap[k*DW +: DW] <= live[k*DW +: DW];
      end
   end

   // R5: the copy changes only on a capture
   a_r5_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cap |=> $stable(snap));

endmodule

// File: rtl/rtcr_store.sv
module rtcr_store
   import rtcr_pkg::*;
#(
   parameter int unsigned DW     = 8,
   parameter int unsigned NBYTES = MAP_BYTES
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [7:0]    wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [7:0]    rd_addr,
   input  logic          sts_rd,
   input  logic          txn_open,
   input  logic          txn_close,
   input  logic          evt_alarm,
   input  logic          bat_mode,
   output logic [DW-1:0] rd_byte,
   output logic          wen
);

   localparam int unsigned IW = $clog2(NBYTES);

   logic [DW-1:0] bytes [NBYTES];
   logic          auto_en, alm_flag, bat_flag, sts_seen;
   logic          wr_sts, auto_clr;

   for (genvar i = 0; i < NBYTES; i++) begin : g_byte
      if (i >= int'(CTL_LO) && i != int'(STS_ADDR) && i != int'(GAP_ADDR)) begin : g_rw
         logic [DW-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        r <= '0;
            else if (wr_en && wr_addr == 8'(i)) r <= wr_data;
         end
         assign bytes[i] = r;
      end else if (i == int'(STS_ADDR)) begin : g_sts
         always_comb begin
            bytes[i]           = '0;
            bytes[i][STS_AUTO] = auto_en;
            bytes[i][STS_WEN]  = wen;
            bytes[i][STS_ALM]  = alm_flag;
            bytes[i][STS_BAT]  = bat_flag;
         end
      end else begin : g_zero
         assign bytes[i] = '0;
      end
   end

   assign wr_sts   = wr_en && (wr_addr == STS_ADDR);
   assign auto_clr = txn_close && auto_en && sts_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         auto_en  <= 1'b0;
         wen      <= 1'b0;
         alm_flag <= 1'b0;
         bat_flag <= 1'b0;
         sts_seen <= 1'b0;
      end else begin
         if (wr_sts) begin
            auto_en <= wr_data[STS_AUTO];
            wen     <= wr_data[STS_WEN];
         end
         if (evt_alarm)     alm_flag <= 1'b1;
         else if (auto_clr) alm_flag <= 1'b0;
         else if (wr_sts)   alm_flag <= alm_flag & wr_data[STS_ALM];
         if (bat_mode)      bat_flag <= 1'b1;
         else if (auto_clr) bat_flag <= 1'b0;
         else if (wr_sts)   bat_flag <= bat_flag & wr_data[STS_BAT];
         if (txn_open || txn_close) sts_seen <= 1'b0;
         else if (sts_rd)           sts_seen <= 1'b1;
      end
   end

   always_comb begin
      if (rd_addr < 8'(NBYTES)) rd_byte = bytes[rd_addr[IW-1:0]];
      else                      rd_byte = '0;
   end

   // R8: flags rise only from their events, never from a write
   a_r8_alm_by_event: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alm_flag) |-> $past(evt_alarm));
   a_r8_bat_by_event: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bat_flag) |-> $past(bat_mode));

   // R9: an auto-clearing stop with no new event leaves the alarm flag low
   a_r9_autoclear: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_close && auto_en && sts_seen && !evt_alarm) |=> !alm_flag);

endmodule

// File: rtl/rtc_regfile_ctrl.sv
module rtc_regfile_ctrl
   import rtcr_pkg::*;
#(
   parameter int unsigned DW = 8,
   parameter int unsigned NB = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bat_mode,
   input  logic             txn_start,
   input  logic             start_addr_vld,
   input  logic [7:0]       start_addr,
   input  logic             wr_valid,
   input  logic [DW-1:0]    wr_data,
   input  logic             rd_req,
   input  logic             txn_stop,
   input  logic             evt_alarm,
   input  logic [NB*DW-1:0] tm_live,
   output logic             rd_valid,
   output logic [DW-1:0]    rd_data,
   output logic             tm_wr_en,
   output logic [7:0]       tm_wr_addr,
   output logic [DW-1:0]    tm_wr_data
);

   localparam int unsigned CLK_BYTES = int'(CLK_HI) + 1;

   if (DW != 8) begin : g_bad_dw
      $error("rtc_regfile_ctrl: status layout needs DW == 8");
   end
   if (NB != CLK_BYTES) begin : g_bad_nb
      $error("rtc_regfile_ctrl: NB must match the clock section size");
   end

   logic          acc, ld, cap, do_wr, do_rd, adv, in_clk, wen;
   logic [7:0]    ptr;
   logic [NB*DW-1:0] snap;
   logic [DW-1:0] store_byte, clk_byte;

   assign acc    = !bat_mode;
   assign ld     = acc && txn_start && start_addr_vld;
   assign cap    = acc && txn_start;
   assign do_wr  = acc && wr_valid;
   assign do_rd  = acc && rd_req && !wr_valid;
   assign adv    = do_wr || do_rd;
   assign in_clk = (sec_of(ptr) == SEC_CLK);

   rtcr_ptr u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (ld),
      .load_addr (start_addr),
      .adv       (adv),
      .ptr       (ptr)
   );

   rtcr_snap #(.DW(DW), .NB(NB)) u_snap (
      .clk   (clk),
      .rst_n (rst_n),
      .cap   (cap),
      .live  (tm_live),
      .snap  (snap)
   );

   rtcr_store #(.DW(DW), .NBYTES(MAP_BYTES)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (do_wr && !in_clk),
      .wr_addr   (ptr),
      .wr_data   (wr_data),
      .rd_addr   (ptr),
      .sts_rd    (do_rd && ptr == STS_ADDR),
      .txn_open  (cap),
      .txn_close (acc && txn_stop),
      .evt_alarm (evt_alarm),
      .bat_mode  (bat_mode),
      .rd_byte   (store_byte),
      .wen       (wen)
   );

   assign clk_byte = snap[int'(ptr[2:0])*DW +: DW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid   <= 1'b0;
         rd_data    <= '0;
         tm_wr_en   <= 1'b0;
         tm_wr_addr <= 8'h00;
         tm_wr_data <= '0;
      end else begin
         rd_valid <= do_rd;
         if (do_rd) rd_data <= in_clk ? clk_byte : store_byte;
         tm_wr_en <= do_wr && in_clk && wen;
         if (do_wr && in_clk) begin
            tm_wr_addr <= ptr;
            tm_wr_data <= wr_data;
         end
      end
   end

   // R6: a clock strobe requires the enable bit in the cycle before
   a_r6_strobe_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      tm_wr_en |-> $past(wen));

   // R6: a strobe always targets the clock section
   a_r6_strobe_in_clock: assert property (@(posedge clk) disable iff (!rst_n)
      tm_wr_en |-> (tm_wr_addr <= CLK_HI));

   // R10: backup mode yields no read response and no clock strobe
   a_r10_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      bat_mode |=> (!rd_valid && !tm_wr_en));

endmodule

// File: tb/sim_rtc_regfile_ctrl.sv
module sim_rtc_regfile_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bat_mode = 1'b0, txn_start = 1'b0, start_addr_vld = 1'b0;
   logic [7:0]  start_addr = 8'h00, wr_data = 8'h00;
   logic        wr_valid = 1'b0, rd_req = 1'b0, txn_stop = 1'b0, evt_alarm = 1'b0;
   logic [55:0] tm_live = '0;
   logic        rd_valid, tm_wr_en;
   logic [7:0]  rd_data, tm_wr_addr, tm_wr_data;

   always #4 clk = ~clk;

   rtc_regfile_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .bat_mode(bat_mode), .txn_start(txn_start),
      .start_addr_vld(start_addr_vld), .start_addr(start_addr),
      .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
      .txn_stop(txn_stop), .evt_alarm(evt_alarm), .tm_live(tm_live),
      .rd_valid(rd_valid), .rd_data(rd_data), .tm_wr_en(tm_wr_en),
      .tm_wr_addr(tm_wr_addr), .tm_wr_data(tm_wr_data)
   );

   int   checks = 0, failures = 0;
   bit   done = 1'b0;

   logic [7:0] m_mem [0:19];
   logic [7:0] m_snap [0:6];
   logic [7:0] m_ptr = 8'h00;
   logic       m_auto = 0, m_wen = 0, m_alm = 0, m_bat = 0, m_seen = 0;

   function automatic logic [7:0] m_nxt(input logic [7:0] a);
      if (a <= 8'h06)      return (a == 8'h06) ? 8'h00 : a + 8'd1;
      else if (a <= 8'h0B) return (a == 8'h0B) ? 8'h07 : a + 8'd1;
      else if (a <= 8'h11) return (a == 8'h11) ? 8'h0C : a + 8'd1;
      else if (a <= 8'h13) return (a == 8'h13) ? 8'h12 : a + 8'd1;
      else                 return a;
   endfunction

   function automatic logic [7:0] m_val(input logic [7:0] a);
      if (a <= 8'h06)      return m_snap[a[2:0]];
      else if (a == 8'h07) return {m_auto, 2'b00, m_wen, 1'b0, m_alm, m_bat, 1'b0};
      else if (a == 8'h09) return 8'h00;
      else if (a <= 8'h13) return m_mem[a[4:0]];
      else                 return 8'h00;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic edge1();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic new_live();
      tm_live = {$urandom(), $urandom()} & 56'hFF_FFFF_FFFF_FFFF;
   endtask

   task automatic t_start(input bit has, input logic [7:0] a);
      new_live();
      txn_start = 1'b1; start_addr_vld = has; start_addr = a;
      edge1();
      txn_start = 1'b0; start_addr_vld = 1'b0;
      if (!bat_mode) begin
         if (has) m_ptr = a;
         for (int k = 0; k < 7; k++) m_snap[k] = tm_live[k*8 +: 8];
         m_seen = 1'b0;
      end
   endtask

   task automatic t_wr(input logic [7:0] d, input bit pulse);
      logic [7:0] a;
      bit exp_tm;
      a = m_ptr;
      new_live();
      wr_valid = 1'b1; wr_data = d; evt_alarm = pulse;
      edge1();
      wr_valid = 1'b0; evt_alarm = 1'b0;
      exp_tm = !bat_mode && (a <= 8'h06) && m_wen;
      chk(tm_wr_en == exp_tm, "R6 strobe", 64'(tm_wr_en), 64'(exp_tm));
      if (exp_tm) begin
         chk(tm_wr_addr == a && tm_wr_data == d, "R6 strobe addr/data",
             {tm_wr_addr, tm_wr_data}, {a, d});
      end
      if (!bat_mode) begin
         if (a == 8'h07) begin
            m_auto = d[7]; m_wen = d[4];
            m_alm = m_alm & d[2]; m_bat = m_bat & d[1];
         end else if (a >= 8'h08 && a != 8'h09 && a <= 8'h13) begin
            m_mem[a[4:0]] = d;
         end
         m_ptr = m_nxt(a);
      end
      if (pulse) m_alm = 1'b1;
   endtask

   task automatic t_rd(input string tag);
      logic [7:0] e;
      e = m_val(m_ptr);
      new_live();
      rd_req = 1'b1;
      edge1();
      rd_req = 1'b0;
      if (bat_mode) begin
         chk(rd_valid == 1'b0, "R10 no read response", 64'(rd_valid), 64'd0);
      end else begin
         chk(rd_valid == 1'b1 && rd_data == e, tag, {rd_valid, rd_data}, {1'b1, e});
         if (m_ptr == 8'h07) m_seen = 1'b1;
         m_ptr = m_nxt(m_ptr);
      end
   endtask

   task automatic t_stop();
      txn_stop = 1'b1;
      edge1();
      txn_stop = 1'b0;
      if (!bat_mode) begin
         if (m_auto && m_seen) begin m_alm = 1'b0; m_bat = 1'b0; end
         m_seen = 1'b0;
      end
   endtask

   task automatic t_alarm();
      evt_alarm = 1'b1;
      edge1();
      evt_alarm = 1'b0;
      m_alm = 1'b1;
   endtask

   task automatic t_batt();
      bat_mode = 1'b1; m_bat = 1'b1;
      edge1();
      t_start(1'b1, 8'h12);
      t_wr(8'($urandom()), 1'b0);
      t_rd("R10");
      t_stop();
      bat_mode = 1'b0;
      edge1();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 20; i++) m_mem[i] = 8'h00;
      for (int i = 0; i < 7; i++) m_snap[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk(rd_valid == 1'b0 && tm_wr_en == 1'b0, "R1 outputs idle", {rd_valid, tm_wr_en}, 64'd0);
      t_start(1'b0, 8'h00);
      t_rd("R1 pointer starts at 00h");
      t_start(1'b1, 8'h07);
      t_rd("R1 status clear");
      t_rd("R1 stored byte clear");
      t_stop();

      // R6: protected clock writes
      t_start(1'b1, 8'h03);
      t_wr(8'h42, 1'b0);
      t_stop();
      t_start(1'b1, 8'h07);
      t_wr(8'h10, 1'b0);
      t_stop();
      t_start(1'b1, 8'h05);
      t_wr(8'hAA, 1'b0);
      t_wr(8'hBB, 1'b0);
      t_wr(8'hCC, 1'b0); // R3 wraps to 00h
      t_stop();

      // R11 and R3: scratch and alarm sections
      t_start(1'b1, 8'h12);
      t_wr(8'h11, 1'b0); t_wr(8'h22, 1'b0); t_wr(8'h33, 1'b0);
      t_start(1'b1, 8'h12);
      t_rd("R11 scratch"); t_rd("R11 scratch"); t_rd("R3 scratch wrap");
      t_stop();
      t_start(1'b1, 8'h10);
      t_wr(8'h5A, 1'b0); t_wr(8'h6B, 1'b0); t_wr(8'h7C, 1'b0);
      t_start(1'b1, 8'h10);
      t_rd("R11 alarm"); t_rd("R11 alarm"); t_rd("R3 alarm wrap");
      t_stop();

      // R7: gap and out-of-map addresses
      t_start(1'b1, 8'h09);
      t_wr(8'hFF, 1'b0);
      t_start(1'b1, 8'h09);
      t_rd("R7 gap reads zero");
      t_start(1'b1, 8'h15);
      t_wr(8'h77, 1'b0);
      t_rd("R7 outside reads zero");
      t_start(1'b0, 8'h00);
      t_rd("R7 outside pointer holds");
      t_stop();

      // R4: current-address continuation and control wrap
      t_start(1'b1, 8'h0A);
      t_rd("R4 control byte");
      t_stop();
      t_start(1'b0, 8'h00);
      t_rd("R4 continue after last read");
      t_rd("R4 control wraps to 07h");
      t_stop();

      // R5: snapshot reads while live time changes
      t_start(1'b1, 8'h00);
      for (int k = 0; k < 8; k++) t_rd("R5 snapshot");
      t_stop();

      // R8: flag set and clear rules
      t_alarm();
      t_start(1'b1, 8'h07);
      t_rd("R8 alarm flag set");
      t_start(1'b1, 8'h07);
      t_wr(8'h14, 1'b0);
      t_start(1'b1, 8'h07);
      t_rd("R8 write one keeps flag");
      t_start(1'b1, 8'h07);
      t_wr(8'h10, 1'b0);
      t_start(1'b1, 8'h07);
      t_rd("R8 write zero clears flag");
      t_start(1'b1, 8'h07);
      t_wr(8'h10, 1'b1);
      t_start(1'b1, 8'h07);
      t_rd("R8 event beats clear");
      t_stop();

      // R9: auto-clear on stop
      t_start(1'b1, 8'h07);
      t_wr(8'h94, 1'b0);
      t_stop();
      t_start(1'b1, 8'h08);
      t_rd("R9 no status read");
      t_stop();
      t_start(1'b1, 8'h07);
      t_rd("R9 flag still set");
      t_stop();
      t_start(1'b1, 8'h07);
      t_rd("R9 flags cleared by stop");
      t_stop();

      // R10: backup mode
      t_batt();
      t_start(1'b1, 8'h12);
      t_rd("R10 storage unchanged");
      t_start(1'b1, 8'h07);
      t_rd("R8 backup flag set");
      t_stop();

      // random mix (R2)
      for (int n = 0; n < 1500; n++) begin
         int unsigned op;
         op = $urandom() % 16;
         if (op <= 2)       t_start(1'b1, 8'($urandom() % 24));
         else if (op == 3)  t_start(1'b0, 8'h00);
         else if (op <= 8)  t_wr(8'($urandom()), ($urandom() % 8) == 0);
         else if (op <= 12) t_rd("R2 random read");
         else if (op == 13) t_stop();
         else if (op == 14) t_alarm();
         else if (($urandom() % 4) == 0) t_batt();
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule